// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide flash bus and turns a single request into the full series of bus write cycles that the flash needs to start a byte program, an erase of one or more sectors, or a chip erase. The caller supplies a command, a target address, a data byte and a sector mask, then pulses a start strobe. The block drives chip enable, write enable, output enable, address and write data itself. Every low or high phase lasts a parameterised number of clock cycles, so the bus timing minimums follow from the clock period.

Once the last command write is on the bus, the block lets go of the data bus and reads the flash repeatedly with output-enable-controlled reads. It compares the top data bit with the value expected at completion. A match ends the operation with a one-cycle done pulse. If a programmable number of reads all mismatch, the block gives up with a one-cycle timeout pulse. In both cases it returns to idle and can accept the next request in that same cycle.

Top module: `flash_pe_sequencer`

## Requirements
- R1: After reset, and whenever idle, chip enable, write enable and output enable are high (inactive), the write-data drive enable is low, and busy, done and timeout are low.
- R2: Command code 0 (byte program) issues four writes in this order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the request data to the request address.
- R3: Command code 1 (sector erase) issues AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh. It then writes 30h to the base of each sector whose mask bit is set, back to back in ascending sector order. A sector base has the sector index in the top SECT_W address bits and zero in all lower bits.
- R4: Command code 2 (chip erase) issues the same five leading writes as R3, followed by a single 10h to 5555h.
- R5: Each write cycle holds write enable low for T_WE_LO clocks and then high for T_WE_HI clocks. Address and write data stay constant for the whole cycle. Chip enable is low, output enable is high and the data bus is driven throughout.
- R6: Before every polling read, the data bus is released and output enable stays high for T_GAP clocks. Each read then holds output enable low for T_RD clocks at the address of the final write cycle, and the data bus is never driven while output enable is low.
- R7: Data bit 7 is sampled in the last clock of each read. The expected value is bit 7 of the request data for a program and 1 for an erase. On a match, done pulses for one clock and busy falls in that same clock.
- R8: If POLL_LIMIT consecutive reads all mismatch, timeout pulses for one clock and the block returns to idle without raising done.
- R9: A start strobe that arrives while busy is ignored and does not change the running sequence.
- R10: A start with command code 3, or a sector erase with an all-zero mask, is ignored: no bus activity, no busy, no done.
- R11: A start strobe in the cycle where done or timeout is high is accepted, and the first write of the new request follows on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe for a request |
| req_cmd | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | ADDR_W | Byte address for a program |
| req_data | input | 8 | Byte to program |
| req_sect_mask | input | 2**SECT_W | One bit per sector to erase |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| timeout | output | 1 | One-clock pulse when polling gives up |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Write data to the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Read data from the flash |

## Verification
Two events can fall in the same clock: the end of one operation (a done or timeout pulse) and the acceptance of the next start strobe. The bench reaches this case by asserting the next request in exactly the clock where its model expects the completion pulse. This happens after a program, after a chip erase and after a timeout. The behavioural reference queue then requires the first write-enable-low clock of the new command sequence on the very next clock. Any lost or delayed start, or any stray extra cycle, shows up as a mismatch.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  typedef enum logic [1:0] {
    CMD_PROG = 2'd0,
    CMD_SECT = 2'd1,
    CMD_CHIP = 2'd2,
    CMD_RSVD = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WLO  = 3'd1,
    ST_WHI  = 3'd2,
    ST_GAP  = 3'd3,
    ST_RD   = 3'd4
  } st_e;

  localparam logic [15:0] UNLOCK_A = 16'h5555;
  localparam logic [15:0] UNLOCK_B = 16'h2AAA;

endpackage

// File: rtl/flseq_sect_pick.sv
module flseq_sect_pick #(
  parameter int SECT_W = 3
) (
  input  logic [(1<<SECT_W)-1:0] mask,
  output logic [(1<<SECT_W)-1:0] first_oh,
  output logic [SECT_W-1:0]      first_idx
);
  localparam int NSECT = 1 << SECT_W;

  logic [SECT_W-1:0] term [NSECT];

  // lowest set bit of the remaining mask
  assign first_oh = mask & (~mask + 1'b1);

  for (genvar g = 0; g < NSECT; g++) begin : g_enc
    assign term[g] = first_oh[g] ? SECT_W'(g) : '0;
  end

  always_comb begin
    first_idx = '0;
    for (int i = 0; i < NSECT; i++) first_idx = first_idx | term[i];
  end

endmodule

// File: rtl/flseq_step_rom.sv
module flseq_step_rom
  import flseq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3
) (
  input  cmd_e              cmd,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        tgt_data,
  input  logic [SECT_W-1:0] sect_idx,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int LOW_W = ADDR_W - SECT_W;

  logic [ADDR_W-1:0] a_key, b_key, sect_base;

  assign a_key     = ADDR_W'(UNLOCK_A);
  assign b_key     = ADDR_W'(UNLOCK_B);
  assign sect_base = {sect_idx, {LOW_W{1'b0}}};

  always_comb begin
    wr_addr = a_key;
    wr_data = 8'hAA;
    unique case (step)
      3'd0: begin wr_addr = a_key; wr_data = 8'hAA; end
      3'd1: begin wr_addr = b_key; wr_data = 8'h55; end
      3'd2: begin
        wr_addr = a_key;
        wr_data = (cmd == CMD_PROG) ? 8'hA0 : 8'h80;
      end
      3'd3: begin
        if (cmd == CMD_PROG) begin
          wr_addr = tgt_addr;
          wr_data = tgt_data;
        end else begin
          wr_addr = a_key;
          wr_data = 8'hAA;
        end
      end
      3'd4: begin wr_addr = b_key; wr_data = 8'h55; end
      default: begin
        if (cmd == CMD_CHIP) begin
          wr_addr = a_key;
          wr_data = 8'h10;
        end else begin
          wr_addr = sect_base;
          wr_data = 8'h30;
        end
      end
    endcase
  end

endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
  import flseq_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int SECT_W     = 3,
  parameter int T_WE_LO    = 3,
  parameter int T_WE_HI    = 2,
  parameter int T_GAP      = 1,
  parameter int T_RD       = 3,
  parameter int POLL_LIMIT = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_start,
  input  logic [1:0]              req_cmd,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [7:0]              req_data,
  input  logic [(1<<SECT_W)-1:0]  req_sect_mask,
  output logic                    busy,
  output logic                    done,
  output logic                    timeout,
  output logic                    fl_ce_n,
  output logic                    fl_we_n,
  output logic                    fl_oe_n,
  output logic [ADDR_W-1:0]       fl_addr,
  output logic [7:0]              fl_dq_out,
  output logic                    fl_dq_oe,
  input  logic [7:0]              fl_dq_in
);
  localparam int NSECT   = 1 << SECT_W;
  localparam int M1      = (T_WE_LO > T_WE_HI) ? T_WE_LO : T_WE_HI;
  localparam int M2      = (T_GAP > T_RD) ? T_GAP : T_RD;
  localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int POLL_W  = $clog2(POLL_LIMIT + 1);

  st_e               st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        step_q, step_d;
  cmd_e              cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        data_q, data_d;
  logic [NSECT-1:0]  mask_q, mask_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic              done_q, done_d;
  logic              tmo_q, tmo_d;

  logic [NSECT-1:0]  cur_oh;
  logic [SECT_W-1:0] cur_idx;
  logic              accept, last_step, final_wr, exp_bit, unused_dq;

  flseq_sect_pick #(.SECT_W(SECT_W)) u_pick (
    .mask      (mask_q),
    .first_oh  (cur_oh),
    .first_idx (cur_idx)
  );

  flseq_step_rom #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_rom (
    .cmd      (cmd_q),
    .step     (step_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .sect_idx (cur_idx),
    .wr_addr  (fl_addr),
    .wr_data  (fl_dq_out)
  );

  assign unused_dq = ^fl_dq_in[6:0];

  assign accept = req_start && (st_q == ST_IDLE) &&
                  ((req_cmd == CMD_PROG) || (req_cmd == CMD_CHIP) ||
                   ((req_cmd == CMD_SECT) && (|req_sect_mask)));

  assign last_step = (cmd_q == CMD_PROG) ? (step_q == 3'd3) : (step_q == 3'd5);
  assign final_wr  = last_step &&
                     ((cmd_q != CMD_SECT) || ((mask_q & ~cur_oh) == '0));
  assign exp_bit   = (cmd_q == CMD_PROG) ? data_q[7] : 1'b1;

  // next-state process
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    step_d = step_q;
    cmd_d  = cmd_q;
    addr_d = addr_q;
    data_d = data_q;
    mask_d = mask_q;
    poll_d = poll_q;
    done_d = 1'b0;
    tmo_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_WLO;
          cnt_d  = '0;
          step_d = '0;
          cmd_d  = cmd_e'(req_cmd);
          addr_d = req_addr;
          data_d = req_data;
          mask_d = req_sect_mask;
          poll_d = '0;
        end
      end
      ST_WLO: begin
        if (cnt_q == CNT_W'(T_WE_LO - 1)) begin
          st_d  = ST_WHI;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WHI: begin
        if (cnt_q == CNT_W'(T_WE_HI - 1)) begin
          cnt_d = '0;
          if (final_wr) begin
            st_d = ST_GAP;
          end else begin
            st_d = ST_WLO;
            if (last_step) mask_d = mask_q & ~cur_oh;
            else           step_d = step_q + 3'd1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == CNT_W'(T_GAP - 1)) begin
          st_d  = ST_RD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RD: begin
        if (cnt_q == CNT_W'(T_RD - 1)) begin
          cnt_d = '0;
          if (fl_dq_in[7] == exp_bit) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else if (poll_q == POLL_W'(POLL_LIMIT - 1)) begin
            st_d  = ST_IDLE;
            tmo_d = 1'b1;
          end else begin
            poll_d = poll_q + 1'b1;
            st_d   = ST_GAP;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      step_q <= '0;
      cmd_q  <= CMD_PROG;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      poll_q <= '0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      step_q <= step_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      data_q <= data_d;
      mask_q <= mask_d;
      poll_q <= poll_d;
      done_q <= done_d;
      tmo_q  <= tmo_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign timeout  = tmo_q;
  assign fl_ce_n  = (st_q == ST_IDLE);
  assign fl_we_n  = (st_q != ST_WLO);
  assign fl_oe_n  = (st_q != ST_RD);
  assign fl_dq_oe = (st_q == ST_WLO) || (st_q == ST_WHI);

  // R5: write enable low only inside a driven write cycle
  p_we_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

  // R5: address and data held while write enable stays low
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

  // R6: bus already released in the clock before a read starts
  p_release_before_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_oe_n) |-> !$past(fl_dq_oe));

  // R6: no drive while the flash drives
  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);

  // R7: completion pulse comes with busy low
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy);

  // R8: done and timeout never together
  p_done_tmo_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  // R9: a strobe while busy leaves the latched request alone
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_start) |=> ((cmd_q == $past(cmd_q)) && (addr_q == $past(addr_q))));

endmodule

// File: tb/tb_flash_pe_sequencer.sv
module tb_flash_pe_sequencer;

  localparam int AW    = 19;
  localparam int SW    = 3;
  localparam int T_LO  = 3;
  localparam int T_HI  = 2;
  localparam int T_GP  = 1;
  localparam int T_RDC = 3;
  localparam int LIMIT = 5;

  typedef struct {
    logic          ce_n, we_n, oe_n, dq_oe, busy, done, tmo;
    logic [AW-1:0] addr;
    logic [7:0]    dat;
    bit            chk_a, chk_d;
    string         tag;
  } exp_t;

  logic          clk, rst_n;
  logic          req_start;
  logic [1:0]    req_cmd;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic [7:0]    req_sect_mask;
  logic          busy, done, timeout;
  logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_out, fl_dq_in;

  int   errors = 0;
  int   checks = 0;
  bit   finished = 0;
  int   read_idx = 0;
  int   ready_after = 0;
  logic exp_bit = 1'b1;
  logic prev_oe = 1'b1;
  exp_t q[$];

  // flash model: complement of the expected bit until ready
  assign fl_dq_in = {((read_idx < ready_after) ? ~exp_bit : exp_bit), 7'h2A};

  flash_pe_sequencer #(
    .ADDR_W(AW), .SECT_W(SW), .T_WE_LO(T_LO), .T_WE_HI(T_HI),
    .T_GAP(T_GP), .T_RD(T_RDC), .POLL_LIMIT(LIMIT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_data(req_data), .req_sect_mask(req_sect_mask),
    .busy(busy), .done(done), .timeout(timeout),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic push(input logic ce, we, oe, dqoe, bsy, dn, tm,
                      input logic [AW-1:0] a, input logic [7:0] d,
                      input bit ca, cd, input string tg);
    exp_t e;
    e.ce_n = ce; e.we_n = we; e.oe_n = oe; e.dq_oe = dqoe;
    e.busy = bsy; e.done = dn; e.tmo = tm;
    e.addr = a; e.dat = d; e.chk_a = ca; e.chk_d = cd; e.tag = tg;
    q.push_back(e);
  endtask

  task automatic push_write(input logic [AW-1:0] a, input logic [7:0] d, input string tg);
    for (int i = 0; i < T_LO; i++) push(0, 0, 1, 1, 1, 0, 0, a, d, 1, 1, {tg, "/R5"});
    for (int i = 0; i < T_HI; i++) push(0, 1, 1, 1, 1, 0, 0, a, d, 1, 1, {tg, "/R5"});
  endtask

  task automatic push_poll(input logic [AW-1:0] a, input int ready);
    for (int k = 0; k < 1000; k++) begin
      for (int i = 0; i < T_GP; i++)  push(0, 1, 1, 0, 1, 0, 0, a, 8'h00, 1, 0, "R6");
      for (int i = 0; i < T_RDC; i++) push(0, 1, 0, 0, 1, 0, 0, a, 8'h00, 1, 0, "R6");
      if (k == ready) begin
        push(1, 1, 1, 0, 0, 1, 0, '0, 8'h00, 0, 0, "R7");
        break;
      end
      if (k + 1 == LIMIT) begin
        push(1, 1, 1, 0, 0, 0, 1, '0, 8'h00, 0, 0, "R8");
        break;
      end
    end
  endtask

  task automatic fail(input string tg, input string what, input int act, input int expv);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tg, what, act, expv);
  endtask

  // one clock: compare every output with the reference queue head (idle if empty, R1)
  task automatic tick();
    exp_t e;
    bit bad;
    @(negedge clk);
    if (prev_oe == 1'b0 && fl_oe_n == 1'b1) read_idx++;
    prev_oe = fl_oe_n;
    if (q.size() > 0) e = q.pop_front();
    else begin
      e.ce_n = 1; e.we_n = 1; e.oe_n = 1; e.dq_oe = 0; e.busy = 0; e.done = 0; e.tmo = 0;
      e.addr = '0; e.dat = '0; e.chk_a = 0; e.chk_d = 0; e.tag = "R1/R10";
    end
    checks++;
    bad = 0;
    if (fl_ce_n !== e.ce_n)  begin fail(e.tag, "ce_n", fl_ce_n, e.ce_n); bad = 1; end
    if (fl_we_n !== e.we_n)  begin fail(e.tag, "we_n", fl_we_n, e.we_n); bad = 1; end
    if (fl_oe_n !== e.oe_n)  begin fail(e.tag, "oe_n", fl_oe_n, e.oe_n); bad = 1; end
    if (fl_dq_oe !== e.dq_oe) begin fail(e.tag, "dq_oe", fl_dq_oe, e.dq_oe); bad = 1; end
    if (busy !== e.busy)     begin fail(e.tag, "busy", busy, e.busy); bad = 1; end
    if (done !== e.done)     begin fail(e.tag, "done", done, e.done); bad = 1; end
    if (timeout !== e.tmo)   begin fail(e.tag, "timeout", timeout, e.tmo); bad = 1; end
    if (e.chk_a && fl_addr !== e.addr)   begin fail(e.tag, "addr", fl_addr, e.addr); bad = 1; end
    if (e.chk_d && fl_dq_out !== e.dat)  begin fail(e.tag, "data", fl_dq_out, e.dat); bad = 1; end
    if (bad) errors = errors - 1 + 1; // already counted per field
  endtask

  task automatic run(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [7:0] d,
                     input logic [7:0] m, input int ready, input bit poke);
    logic [AW-1:0] last_a;
    string tg;
    exp_bit     = (cmd == 2'd0) ? d[7] : 1'b1;
    ready_after = ready;
    read_idx    = 0;
    if (cmd == 2'd0) begin
      // R2: program sequence
      push_write(19'h05555, 8'hAA, "R2");
      push_write(19'h02AAA, 8'h55, "R2");
      push_write(19'h05555, 8'hA0, "R2");
      push_write(a, d, "R2");
      last_a = a;
    end else begin
      tg = (cmd == 2'd1) ? "R3" : "R4";
      push_write(19'h05555, 8'hAA, tg);
      push_write(19'h02AAA, 8'h55, tg);
      push_write(19'h05555, 8'h80, tg);
      push_write(19'h05555, 8'hAA, tg);
      push_write(19'h02AAA, 8'h55, tg);
      last_a = 19'h05555;
      if (cmd == 2'd2) push_write(19'h05555, 8'h10, "R4");
      else begin
        for (int s = 0; s < 8; s++) begin
          if (m[s]) begin
            last_a = {3'(s), 16'h0000};
            push_write(last_a, 8'h30, "R3");
          end
        end
      end
    end
    push_poll(last_a, ready);
    req_cmd = cmd; req_addr = a; req_data = d; req_sect_mask = m;
    req_start = 1'b1;
    tick();
    req_start = 1'b0;
    if (poke) begin
      // R9: strobe with a different request while busy
      repeat (3) tick();
      req_start = 1'b1; req_cmd = 2'd2; req_addr = 19'h7FFFF; req_data = 8'h00;
      tick(); tick();
      req_start = 1'b0;
    end
    while (q.size() > 0) tick();
  endtask

  initial begin
    req_start = 0; req_cmd = 0; req_addr = '0; req_data = '0; req_sect_mask = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, busy, done, timeout} !== 7'b1110000)
      fail("R1", "reset outputs", {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, busy, done, timeout}, 7'b1110000);
    rst_n = 1'b1;
    repeat (2) tick();

    run(2'd0, 19'h12345, 8'hC3, 8'h00, 2, 1'b1);  // R2, R7 with bit7=1, R9
    run(2'd0, 19'h00F0F, 8'h3C, 8'h00, 0, 1'b0);  // R11 back to back, R7 with bit7=0
    repeat (3) tick();
    run(2'd1, 19'h00000, 8'h00, 8'hA4, 1, 1'b0);  // R3 sectors 2,5,7
    run(2'd2, 19'h00000, 8'h00, 8'h00, 3, 1'b0);  // R4, R11
    run(2'd0, 19'h7FFFF, 8'h80, 8'h00, 0, 1'b0);  // R11 after chip erase
    repeat (2) tick();

    // R10: empty mask sector erase and reserved code are ignored
    req_cmd = 2'd1; req_sect_mask = 8'h00; req_start = 1'b1; tick();
    req_cmd = 2'd3; req_sect_mask = 8'hFF; tick();
    req_start = 1'b0;
    repeat (4) tick();

    run(2'd0, 19'h01234, 8'h11, 8'h00, 100, 1'b0); // R8 timeout
    run(2'd1, 19'h00000, 8'h00, 8'hFF, 0, 1'b0);   // R11 after timeout, R3 all sectors
    run(2'd1, 19'h00000, 8'h00, 8'h01, 4, 1'b0);   // R3 single sector 0, R8 boundary: match on last allowed read
    repeat (3) tick();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule